// File: doc/BRIEF.md
# Banked Internal Data Memory

This block is the 256-byte on-chip data space of a small 8-bit controller core. The core presents one access per cycle, tagged with an addressing mode, and the block resolves it to a physical byte. Working-register operands are remapped into one of four 8-byte banks chosen by a 2-bit bank select, so the first 32 bytes serve as four register files. A pointer-based access first fetches R0 or R1 of the active bank and then uses that value as the target address. Bit operands address individual bits of a sixteen-byte window at 20h.

Direct and bit accesses that fall in the upper half of the address space are not served from RAM. Instead they are passed on, in the same cycle, to the special-function-register logic that sits beside this block. Pointer accesses always reach RAM, so all 256 bytes are backed by storage. Reads return one cycle after a single-phase request, or two cycles after a pointer request. While the second phase of a pointer access runs, the block holds `busy` and ignores new requests.

Top module: `banked_iram`

## Requirements
- R1: A direct-mode request (mode 00) to an address below 80h reads or writes that RAM byte. A read raises `rd_valid` with the byte on `rd_data` in the cycle after the request.
- R2: A direct-mode request to an address of 80h or above raises `sfr_strobe` in the same cycle, with `sfr_addr` equal to the address, `sfr_we` equal to the request's write flag and `sfr_wdata` equal to the write data. It does not change RAM and does not raise `rd_valid`.
- R3: A register-mode request (mode 01) with register number n in address bits [2:0] accesses byte {bank_sel, n}. The four banks are independent storage.
- R4: A pointer-mode request (mode 10) reads R0 (address bit 0 = 0) or R1 (address bit 0 = 1) of the active bank and accesses the byte it holds. `busy` is high in the following cycle, and read data appears with `rd_valid` two cycles after the request.
- R5: A pointer access whose target is 80h or above reaches RAM and never raises `sfr_strobe`.
- R6: A request presented while `busy` is high has no effect.
- R7: A bit-mode request (mode 11) with bit address b below 80h selects bit b[2:0] of byte 20h + (b >> 3). A read returns that bit on `rd_bit` and the whole byte on `rd_data` one cycle later.
- R8: A bit-mode write changes only the selected bit of its byte and raises no `rd_valid`.
- R9: A bit-mode request with b of 80h or above raises `sfr_strobe` with `sfr_bit_op` high, `sfr_addr` = {b[7:3], 000}, `sfr_bit_idx` = b[2:0] and `sfr_wdata` filled with the bit value.
- R10: During and right after reset, `rd_valid`, `busy` and `sfr_strobe` are low and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_mode | input | 2 | 00 direct, 01 register, 10 pointer, 11 bit |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address, register number, pointer select or bit address |
| req_wdata | input | 8 | Write byte |
| req_wbit | input | 1 | Bit value for bit writes |
| bank_sel | input | 2 | Active register bank |
| busy | output | 1 | Second phase of a pointer access in progress |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read byte |
| rd_bit | output | 1 | Selected bit for bit reads |
| sfr_strobe | output | 1 | Access handed to special-function logic |
| sfr_we | output | 1 | Handed-off access is a write |
| sfr_addr | output | 8 | Handed-off byte address |
| sfr_wdata | output | 8 | Handed-off write data |
| sfr_bit_op | output | 1 | Handed-off access is a bit operation |
| sfr_bit_idx | output | 3 | Bit index of a handed-off bit operation |

## Verification
The bench writes the same register number in two banks and reads both back, so a design that ignored the bank select would return the last value written. It plants a pointer to 90h and to 85h, so a design that sent pointer accesses to the special-function path would raise the strobe and lose the RAM contents. It also presents a write during the busy cycle, which a design without the guard would commit. Bit writes at the edges of the bit window (bit 4 of 21h, bit 7 of 2Fh) show whether neighbouring bits are disturbed or the byte offset is miscounted.

// File: rtl/biram_pkg.sv
package biram_pkg;
  typedef enum logic [1:0] {
    AM_DIRECT = 2'b00,
    AM_REG    = 2'b01,
    AM_PTR    = 2'b10,
    AM_BIT    = 2'b11
  } amode_e;

  typedef enum logic {
    PH_IDLE   = 1'b0,
    PH_SECOND = 1'b1
  } phase_e;
endpackage

// File: rtl/biram_resolve.sv
module biram_resolve
  import biram_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int BANKS     = 4,
  parameter int BANK_REGS = 8,
  parameter int BIT_BASE  = 32
) (
  input  logic [1:0]                 mode,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [$clog2(BANKS)-1:0]   bank,
  output logic [ADDR_W-1:0]          byte_addr,
  output logic [ADDR_W-1:0]          ptr_addr,
  output logic [$clog2(DATA_W)-1:0]  bit_idx,
  output logic                       hits_sfr
);
  localparam int REG_W  = $clog2(BANK_REGS);
  localparam int BIDX_W = $clog2(DATA_W);
  localparam int MSB    = ADDR_W - 1;

  // pointer register: R0 or R1 of the active bank
  assign ptr_addr = ADDR_W'({bank, REG_W'(addr[0])});
  assign bit_idx  = addr[BIDX_W-1:0];

  always_comb begin
    byte_addr = addr;
    hits_sfr  = 1'b0;
    case (amode_e'(mode))
      AM_DIRECT: begin
        byte_addr = addr;
        hits_sfr  = addr[MSB];
      end
      AM_REG: begin
        byte_addr = ADDR_W'({bank, addr[REG_W-1:0]});
      end
      AM_PTR: begin
        byte_addr = ptr_addr;
      end
      AM_BIT: begin
        if (addr[MSB]) begin
          byte_addr = {addr[MSB:BIDX_W], {BIDX_W{1'b0}}};
          hits_sfr  = 1'b1;
        end else begin
          byte_addr = ADDR_W'(BIT_BASE) + (addr >> BIDX_W);
        end
      end
      default: byte_addr = addr;
    endcase
  end
endmodule

// File: rtl/biram_store.sv
module biram_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data_a = mem_q[rd_addr_a];
  assign rd_data_b = mem_q[rd_addr_b];
endmodule

// File: rtl/biram_seq.sv
module biram_seq
  import biram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] ptr_val,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic              tgt_we,
  output logic [DATA_W-1:0] tgt_wdata,
  input  logic              rd_fire,
  input  logic [DATA_W-1:0] rd_byte,
  input  logic              rd_bit_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_bit
);
  phase_e            phase_q, phase_d;
  logic              rv_d;
  logic [DATA_W-1:0] rdat_d;
  logic              rbit_d;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE:   if (start) phase_d = PH_SECOND;
      PH_SECOND: phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
    rv_d   = rd_fire;
    rdat_d = rd_fire ? rd_byte : rd_data;
    rbit_d = rd_fire ? rd_bit_in : rd_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_bit   <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      rd_valid <= rv_d;
      rd_data  <= rdat_d;
      rd_bit   <= rbit_d;
    end
  end

  // second-phase target, loaded only when a pointer access starts
  always_ff @(posedge clk) begin
    if (start) begin
      tgt_addr  <= ptr_val;
      tgt_we    <= req_we;
      tgt_wdata <= req_wdata;
    end
  end

  assign busy = (phase_q == PH_SECOND);
endmodule

// File: rtl/banked_iram.sv
module banked_iram
  import biram_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int BANKS     = 4,
  parameter int BANK_REGS = 8,
  parameter int BIT_BASE  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_mode,
  input  logic              req_we,
  input  logic [7:0]        req_addr,
  input  logic [7:0]        req_wdata,
  input  logic              req_wbit,
  input  logic [1:0]        bank_sel,
  output logic              busy,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              rd_bit,
  output logic              sfr_strobe,
  output logic              sfr_we,
  output logic [7:0]        sfr_addr,
  output logic [7:0]        sfr_wdata,
  output logic              sfr_bit_op,
  output logic [2:0]        sfr_bit_idx
);
  localparam int BIDX_W = $clog2(DATA_W);

  logic              acc, is_ptr, is_bit, ram_acc;
  logic [ADDR_W-1:0] byte_addr, ptr_addr, tgt_addr, port_a_addr;
  logic [BIDX_W-1:0] bit_idx, sel_idx;
  logic              hits_sfr;
  logic [DATA_W-1:0] rdata_a, rdata_b, merged, wr_data, tgt_wdata;
  logic              wr_en, tgt_we, rd_fire;

  assign acc     = req_valid & ~busy;
  assign is_ptr  = (amode_e'(req_mode) == AM_PTR);
  assign is_bit  = (amode_e'(req_mode) == AM_BIT);
  assign ram_acc = acc & ~is_ptr & ~hits_sfr;

  biram_resolve #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANKS(BANKS),
    .BANK_REGS(BANK_REGS), .BIT_BASE(BIT_BASE)
  ) u_resolve (
    .mode      (req_mode),
    .addr      (req_addr),
    .bank      (bank_sel),
    .byte_addr (byte_addr),
    .ptr_addr  (ptr_addr),
    .bit_idx   (bit_idx),
    .hits_sfr  (hits_sfr)
  );

  assign port_a_addr = busy ? tgt_addr : byte_addr;

  biram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .wr_en     (wr_en),
    .wr_addr   (port_a_addr),
    .wr_data   (wr_data),
    .rd_addr_a (port_a_addr),
    .rd_data_a (rdata_a),
    .rd_addr_b (ptr_addr),
    .rd_data_b (rdata_b)
  );

  // read-modify-write merge for bit writes
  always_comb begin
    merged          = rdata_a;
    merged[bit_idx] = req_wbit;
  end

  assign sel_idx = busy ? '0 : bit_idx;
  assign wr_en   = busy ? tgt_we : (ram_acc & req_we);
  assign wr_data = busy ? tgt_wdata : (is_bit ? merged : req_wdata);
  assign rd_fire = busy ? ~tgt_we : (ram_acc & ~req_we);

  biram_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (acc & is_ptr),
    .ptr_val   (ADDR_W'(rdata_b)),
    .req_we    (req_we),
    .req_wdata (req_wdata),
    .busy      (busy),
    .tgt_addr  (tgt_addr),
    .tgt_we    (tgt_we),
    .tgt_wdata (tgt_wdata),
    .rd_fire   (rd_fire),
    .rd_byte   (rdata_a),
    .rd_bit_in (rdata_a[sel_idx]),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_bit    (rd_bit)
  );

  // hand-off to the special-function-register logic
  assign sfr_strobe  = acc & ~is_ptr & hits_sfr;
  assign sfr_we      = sfr_strobe & req_we;
  assign sfr_addr    = byte_addr;
  assign sfr_wdata   = is_bit ? {DATA_W{req_wbit}} : req_wdata;
  assign sfr_bit_op  = sfr_strobe & is_bit;
  assign sfr_bit_idx = bit_idx;
endmodule

// File: rtl/banked_iram_chk.sv
module banked_iram_chk
  import biram_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] req_mode,
  input logic       req_we,
  input logic [7:0] req_addr,
  input logic       busy,
  input logic       rd_valid,
  input logic       sfr_strobe,
  input logic       sfr_bit_op
);
  logic acc;
  assign acc = req_valid && !busy;

  p_read_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_mode == AM_DIRECT && !req_addr[7] && !req_we |=> rd_valid);

  p_sfr_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_mode == AM_DIRECT && req_addr[7] |=> !rd_valid);

  p_reg_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_mode == AM_REG && !req_we |=> rd_valid);

  p_ptr_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_mode == AM_PTR |=> busy && !rd_valid);

  p_ptr_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_mode == AM_PTR && !req_we |=> ##1 rd_valid);

  p_ptr_no_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sfr_strobe);

  p_busy_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  p_bit_write_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_mode == AM_BIT && req_we |=> !rd_valid);

  p_bit_handoff_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_bit_op |-> sfr_strobe && req_mode == AM_BIT);
endmodule

bind banked_iram banked_iram_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_mode   (req_mode),
  .req_we     (req_we),
  .req_addr   (req_addr),
  .busy       (busy),
  .rd_valid   (rd_valid),
  .sfr_strobe (sfr_strobe),
  .sfr_bit_op (sfr_bit_op)
);

// File: tb/tb_banked_iram.sv
module tb_banked_iram;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_we, req_wbit;
  logic [1:0] req_mode, bank_sel;
  logic [7:0] req_addr, req_wdata;
  logic       busy, rd_valid, rd_bit, sfr_strobe, sfr_we, sfr_bit_op;
  logic [7:0] rd_data, sfr_addr, sfr_wdata;
  logic [2:0] sfr_bit_idx;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  banked_iram dut (.*);

  // vector: mode[31:30] we[29] bank[28:27] addr[26:19] wdata[18:11]
  //         wbit[10] chk[9] exp_byte[8:1] exp_bit[0]
  localparam int NV = 22;
  localparam logic [31:0] VEC [NV] = '{
    {2'd0,1'b1,2'd0,8'h05,8'hA5,1'b0,1'b0,8'h00,1'b0}, // R1 write
    {2'd0,1'b0,2'd0,8'h05,8'h00,1'b0,1'b1,8'hA5,1'b0}, // R1 read
    {2'd1,1'b1,2'd1,8'h03,8'h3C,1'b0,1'b0,8'h00,1'b0}, // R3 bank1 R3 -> 0Bh
    {2'd0,1'b0,2'd0,8'h0B,8'h00,1'b0,1'b1,8'h3C,1'b0}, // R3 seen at 0Bh
    {2'd1,1'b1,2'd0,8'h03,8'hC3,1'b0,1'b0,8'h00,1'b0}, // R3 bank0 R3
    {2'd1,1'b0,2'd1,8'h03,8'h00,1'b0,1'b1,8'h3C,1'b0}, // R3 bank1 kept
    {2'd1,1'b0,2'd0,8'h03,8'h00,1'b0,1'b1,8'hC3,1'b0}, // R3 bank0
    {2'd1,1'b1,2'd2,8'h00,8'h40,1'b0,1'b0,8'h00,1'b0}, // bank2 R0 = 40h
    {2'd1,1'b1,2'd2,8'h01,8'h90,1'b0,1'b0,8'h00,1'b0}, // bank2 R1 = 90h
    {2'd0,1'b1,2'd0,8'h40,8'h77,1'b0,1'b0,8'h00,1'b0},
    {2'd2,1'b0,2'd2,8'h00,8'h00,1'b0,1'b1,8'h77,1'b0}, // R4 via R0
    {2'd2,1'b1,2'd2,8'h01,8'h5E,1'b0,1'b0,8'h00,1'b0}, // R5 write 90h
    {2'd2,1'b0,2'd2,8'h01,8'h00,1'b0,1'b1,8'h5E,1'b0}, // R5 read 90h
    {2'd0,1'b1,2'd0,8'h21,8'h00,1'b0,1'b0,8'h00,1'b0},
    {2'd3,1'b1,2'd0,8'h0C,8'h00,1'b1,1'b0,8'h00,1'b0}, // R8 set 21h.4
    {2'd0,1'b0,2'd0,8'h21,8'h00,1'b0,1'b1,8'h10,1'b0}, // R8 only bit 4
    {2'd3,1'b0,2'd0,8'h0C,8'h00,1'b0,1'b1,8'h10,1'b1}, // R7 read bit
    {2'd0,1'b1,2'd0,8'h2F,8'hFF,1'b0,1'b0,8'h00,1'b0},
    {2'd3,1'b1,2'd0,8'h7F,8'h00,1'b0,1'b0,8'h00,1'b0}, // R8 clear 2Fh.7
    {2'd0,1'b0,2'd0,8'h2F,8'h00,1'b0,1'b1,8'h7F,1'b0}, // R8
    {2'd3,1'b0,2'd0,8'h7E,8'h00,1'b0,1'b1,8'h7F,1'b1}, // R7 last byte
    {2'd3,1'b0,2'd0,8'h7F,8'h00,1'b0,1'b1,8'h7F,1'b0}  // R7 cleared bit
  };

  function automatic string tag_of(input logic [1:0] m);
    case (m)
      2'd0: return "R1";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid = 1'b0; req_mode = 2'd0; req_we = 1'b0; req_addr = '0;
    req_wdata = '0; req_wbit = 1'b0; bank_sel = '0;
  endtask

  // drives one request; returns at the negedge where read data is visible
  task automatic issue(input logic [1:0] m, input logic w, input logic [1:0] b,
                       input logic [7:0] a, input logic [7:0] d, input logic wb);
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_we = w; bank_sel = b;
    req_addr = a; req_wdata = d; req_wbit = wb;
    @(negedge clk);
    req_valid = 1'b0;
    if (m == 2'd2) begin
      check("R4 busy", {31'd0, busy}, 32'd1);
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 rd_valid", {31'd0, rd_valid}, 32'd0);
    check("R10 busy", {31'd0, busy}, 32'd0);
    check("R10 strobe", {31'd0, sfr_strobe}, 32'd0);
    check("R10 rd_data", {24'd0, rd_data}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after release", {30'd0, rd_valid, busy}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      issue(v[31:30], v[29], v[28:27], v[26:19], v[18:11], v[10]);
      if (!v[29]) check(tag_of(v[31:30]), {31'd0, rd_valid}, 32'd1);
      else        check("R8 write no read", {31'd0, rd_valid}, 32'd0);
      if (v[9]) begin
        check(tag_of(v[31:30]), {24'd0, rd_data}, {24'd0, v[8:1]});
        if (v[31:30] == 2'd3) check("R7 bit", {31'd0, rd_bit}, {31'd0, v[0]});
      end
    end

    // R6: request during busy is dropped; R5: no strobe while busy
    @(negedge clk);
    req_valid = 1'b1; req_mode = 2'd2; req_we = 1'b0; bank_sel = 2'd2; req_addr = 8'h00;
    @(negedge clk);
    check("R6 busy", {31'd0, busy}, 32'd1);
    req_mode = 2'd0; req_we = 1'b1; bank_sel = 2'd0; req_addr = 8'h05; req_wdata = 8'h00;
    #1 check("R5 no strobe", {31'd0, sfr_strobe}, 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    check("R4 ptr data", {23'd0, rd_valid, rd_data}, {23'd0, 1'b1, 8'h77});
    issue(2'd0, 1'b0, 2'd0, 8'h05, 8'h00, 1'b0);
    check("R6 ignored write", {24'd0, rd_data}, 32'h000000A5);

    // R2: direct upper access goes to the strobe and leaves RAM alone
    issue(2'd1, 1'b1, 2'd3, 8'h00, 8'h85, 1'b0);
    issue(2'd2, 1'b1, 2'd3, 8'h00, 8'h11, 1'b0);
    check("R5 ptr write no strobe", {31'd0, sfr_strobe}, 32'd0);
    @(negedge clk);
    req_valid = 1'b1; req_mode = 2'd0; req_we = 1'b1; req_addr = 8'h85; req_wdata = 8'h22;
    #1 check("R2 strobe", {15'd0, sfr_strobe, sfr_we, sfr_bit_op, sfr_addr, sfr_wdata},
             {15'd0, 1'b1, 1'b1, 1'b0, 8'h85, 8'h22});
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 no rd_valid", {31'd0, rd_valid}, 32'd0);
    issue(2'd0, 1'b0, 2'd0, 8'h85, 8'h00, 1'b0);
    check("R2 read no rd_valid", {31'd0, rd_valid}, 32'd0);
    issue(2'd2, 1'b0, 2'd3, 8'h00, 8'h00, 1'b0);
    check("R2 RAM 85h kept", {23'd0, rd_valid, rd_data}, {23'd0, 1'b1, 8'h11});

    // R9: bit address in upper half handed off
    @(negedge clk);
    req_valid = 1'b1; req_mode = 2'd3; req_we = 1'b1; req_addr = 8'h8B; req_wbit = 1'b1;
    #1 check("R9 handoff", {17'd0, sfr_strobe, sfr_bit_op, sfr_bit_idx, sfr_addr},
             {17'd0, 1'b1, 1'b1, 3'd3, 8'h88});
    check("R9 wdata", {24'd0, sfr_wdata}, 32'h000000FF);
    @(negedge clk);
    idle_inputs();
    check("R9 no rd_valid", {31'd0, rd_valid}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule